// File: doc/BRIEF.md
# Calendar-Ordered Flow-Control Status Sender

This block produces a continuous stream of 2-bit flow-control status slots for up to 256 channels. The order of the slots comes from a writable calendar: a memory of 8-bit channel numbers that software loads through a small configuration port. A separate status port loads the current 2-bit status of 16 channels per clock cycle into a status store. The transmit side walks the calendar from entry 0 up to a programmable length. It repeats that walk a programmable number of times per frame. Each frame opens with a framing code and closes with a DIP-2 parity word.

For link testing, a request input forces one deliberately wrong parity word. The whole block runs on a single clock.

The transmit sequencer has four states. IDLE is entered only on reset, and its only exit is IDLE to SYNC on the first clock. SYNC emits the framing code and latches the length and repeat settings; it always moves SYNC to SLOT. SLOT emits one calendar entry's status per cycle. It stays in SLOT until the last entry of the last repetition, then moves SLOT to PARITY. PARITY emits the parity word and always moves PARITY to SYNC, so frames follow each other with no gap.

Top module: `lnk_stat_tx`

## Requirements
- R1: While `cal_we_n` is low, the rising clock edge stores `cal_wdata` at calendar address `cal_addr`.
- R2: `cal_rdata` always shows the channel number held at calendar address `cal_addr`.
- R3: When `st_wr` is high at a rising edge, channel `st_grp*16+k` (k = 0..15) takes `st_data[2k+1:2k]`. Channel 16*g sits in bits [1:0].
- R4: After reset, every channel's status is 2'b00 until it is written.
- R5: Each frame is one SYNC slot carrying 2'b11 with `frame_mark` high. L*N status slots follow, then one parity slot. The next frame's SYNC slot comes straight after. `frame_mark` is low outside SYNC.
- R6: Within a frame, repetition r (0..N-1) sends the status of the channels held at calendar addresses 0..L-1 in ascending order. The value sent is the status current in that cycle.
- R7: L and N are taken from `cal_len` and `cal_reps` during the SYNC slot, and later changes wait for the next frame. A value of 0 counts as 1, and `cal_len` above 512 counts as 512.
- R8: The parity word is ~A. A starts at 2'b00 and, for each status slot s, becomes {A[0],A[1]} XOR s. The framing slot is excluded.
- R9: A rising edge of `dip_err_req` inverts the next parity word sent, and only that one. Holding the request high corrupts no further frames until it falls and rises again.
- R10: While `rst_n` is low, `stat_out` is 2'b00 and `frame_mark` is low. The first SYNC slot starts one clock after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for every part of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_we_n | input | 1 | Calendar write strobe, active low |
| cal_addr | input | 9 | Calendar address for write and read |
| cal_wdata | input | 8 | Channel number to store |
| cal_rdata | output | 8 | Channel number held at `cal_addr` |
| cal_len | input | 10 | Calendar entries walked per repetition |
| cal_reps | input | 4 | Repetitions of the calendar walk per frame |
| st_wr | input | 1 | Status group write strobe |
| st_grp | input | 4 | Index of the 16-channel group being written |
| st_data | input | 32 | Sixteen 2-bit status values, lowest channel in bits [1:0] |
| dip_err_req | input | 1 | Rising edge requests one inverted parity word |
| stat_out | output | 2 | Status link slot value |
| frame_mark | output | 1 | High during the framing slot |

## Verification
The checker's calendar property assumes a write is followed by a read of the same address. It also assumes nothing else writes that address in between. The bench keeps to this by issuing each calendar write as a single-cycle strobe and reading back only after the strobe drops. The framing properties assume `cal_len` and `cal_reps` hold stable only around the SYNC slot. The bench therefore changes them mid-frame deliberately, to show that only the following frame picks them up. The error request is raised only as a clean low-to-high step in the middle of a frame, so the corrupted parity word is known without ambiguity.

// File: rtl/lst_pkg.sv
package lst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_SLOT   = 2'd2,
        ST_PARITY = 2'd3
    } lst_state_e;

    localparam logic [1:0] SYNC_CODE = 2'b11;

endpackage

// File: rtl/lst_cal_ram.sv
module lst_cal_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_n,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic [AW-1:0] tx_addr,
    output logic [DW-1:0] tx_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!we_n) begin
            mem[cfg_addr] <= cfg_wdata;
        end
    end

    // Two asynchronous read ports: one for configuration, one for the sender.
    always_comb begin
        cfg_rdata = mem[cfg_addr];
        tx_rdata  = mem[tx_addr];
    end
endmodule

// File: rtl/lst_stat_bank.sv
module lst_stat_bank #(
    parameter int CHAN_W = 8,
    parameter int GRP_CH = 16,
    parameter int SW     = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [GW-1:0]            grp,
    input  logic [GRP_CH*SW-1:0]     data,
    input  logic [CHAN_W-1:0]        rd_chan,
    output logic [SW-1:0]            rd_stat
);
    localparam int NUM_CH  = 1 << CHAN_W;
    localparam int NUM_GRP = NUM_CH / GRP_CH;
    localparam int GW      = $clog2(NUM_GRP);

    logic [SW-1:0] stat_q [NUM_CH];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar k = 0; k < GRP_CH; k++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stat_q[g*GRP_CH+k] <= '0;
                end else if (wr && grp == GW'(g)) begin
                    stat_q[g*GRP_CH+k] <= data[k*SW +: SW];
                end
            end
        end
    end

    assign rd_stat = stat_q[rd_chan];
endmodule

// File: rtl/lst_dip.sv
module lst_dip #(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          fold_en,
    input  logic [SW-1:0] slot,
    input  logic          err_req,
    input  logic          consume,
    output logic [SW-1:0] dip_word
);
    logic [SW-1:0] acc_q;
    logic          req_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (fold_en) begin
            acc_q <= {acc_q[0], acc_q[SW-1:1]} ^ slot;
        end
    end

    // Edge-detected request; a new edge wins over consumption.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            req_q <= err_req;
            if (err_req && !req_q) begin
                pend_q <= 1'b1;
            end else if (consume) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign dip_word = ~acc_q ^ {SW{pend_q}};
endmodule

// File: rtl/lst_seq.sv
module lst_seq
    import lst_pkg::*;
#(
    parameter int AW    = 9,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW:0]      cal_len,
    input  logic [REP_W-1:0] cal_reps,
    output lst_state_e       state,
    output logic [AW-1:0]    slot_idx,
    output logic             frame_mark,
    output logic             slot_en,
    output logic             parity_en,
    output logic             acc_clr
);
    localparam int DEPTH = 1 << AW;

    lst_state_e       st_q, st_d;
    logic [AW-1:0]    idx_q, last_idx_q, len_m1;
    logic [REP_W-1:0] rep_q, last_rep_q, reps_m1;
    logic             last_slot;

    always_comb begin
        if (cal_len == '0) begin
            len_m1 = '0;
        end else if (cal_len > (AW+1)'(DEPTH)) begin
            len_m1 = AW'(DEPTH - 1);
        end else begin
            len_m1 = AW'(cal_len - (AW+1)'(1));
        end
        reps_m1 = (cal_reps == '0) ? '0 : cal_reps - REP_W'(1);
    end

    assign last_slot = (idx_q == last_idx_q) && (rep_q == last_rep_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = ST_SYNC;
            ST_SYNC:   st_d = ST_SLOT;
            ST_SLOT:   st_d = last_slot ? ST_PARITY : ST_SLOT;
            ST_PARITY: st_d = ST_SYNC;
        endcase
    end

    // Calendar walk counters; settings latched during the framing slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            rep_q      <= '0;
            last_idx_q <= '0;
            last_rep_q <= '0;
        end else if (st_q == ST_SYNC) begin
            idx_q      <= '0;
            rep_q      <= '0;
            last_idx_q <= len_m1;
            last_rep_q <= reps_m1;
        end else if (st_q == ST_SLOT) begin
            if (idx_q == last_idx_q) begin
                idx_q <= '0;
                rep_q <= rep_q + REP_W'(1);
            end else begin
                idx_q <= idx_q + AW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        frame_mark = 1'b0;
        slot_en    = 1'b0;
        parity_en  = 1'b0;
        acc_clr    = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_SYNC:   begin frame_mark = 1'b1; acc_clr = 1'b1; end
            ST_SLOT:   slot_en = 1'b1;
            ST_PARITY: parity_en = 1'b1;
        endcase
    end

    assign state    = st_q;
    assign slot_idx = idx_q;
endmodule

// File: rtl/lnk_stat_tx.sv
module lnk_stat_tx
    import lst_pkg::*;
#(
    parameter int CAL_AW = 9,
    parameter int CHAN_W = 8,
    parameter int GRP_CH = 16,
    parameter int SW     = 2,
    parameter int REP_W  = 4,
    localparam int GW    = $clog2((1 << CHAN_W) / GRP_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_we_n,
    input  logic [CAL_AW-1:0]    cal_addr,
    input  logic [CHAN_W-1:0]    cal_wdata,
    output logic [CHAN_W-1:0]    cal_rdata,
    input  logic [CAL_AW:0]      cal_len,
    input  logic [REP_W-1:0]     cal_reps,
    input  logic                 st_wr,
    input  logic [GW-1:0]        st_grp,
    input  logic [GRP_CH*SW-1:0] st_data,
    input  logic                 dip_err_req,
    output logic [SW-1:0]        stat_out,
    output logic                 frame_mark
);
    lst_state_e        state;
    logic [CAL_AW-1:0] slot_idx;
    logic [CHAN_W-1:0] tx_chan;
    logic [SW-1:0]     slot_stat, dip_word;
    logic              slot_en, parity_en, acc_clr;

    lst_cal_ram #(.AW(CAL_AW), .DW(CHAN_W)) u_cal (
        .clk      (clk),
        .we_n     (cal_we_n),
        .cfg_addr (cal_addr),
        .cfg_wdata(cal_wdata),
        .cfg_rdata(cal_rdata),
        .tx_addr  (slot_idx),
        .tx_rdata (tx_chan)
    );

    lst_stat_bank #(.CHAN_W(CHAN_W), .GRP_CH(GRP_CH), .SW(SW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (st_wr),
        .grp    (st_grp),
        .data   (st_data),
        .rd_chan(tx_chan),
        .rd_stat(slot_stat)
    );

    lst_seq #(.AW(CAL_AW), .REP_W(REP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_len   (cal_len),
        .cal_reps  (cal_reps),
        .state     (state),
        .slot_idx  (slot_idx),
        .frame_mark(frame_mark),
        .slot_en   (slot_en),
        .parity_en (parity_en),
        .acc_clr   (acc_clr)
    );

    lst_dip #(.SW(SW)) u_dip (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .fold_en (slot_en),
        .slot    (slot_stat),
        .err_req (dip_err_req),
        .consume (parity_en),
        .dip_word(dip_word)
    );

    always_comb begin
        stat_out = '0;
        unique case (state)
            ST_IDLE:   stat_out = '0;
            ST_SYNC:   stat_out = SW'(SYNC_CODE);
            ST_SLOT:   stat_out = slot_stat;
            ST_PARITY: stat_out = dip_word;
        endcase
    end
endmodule

// File: rtl/lst_chk.sv
module lst_chk #(
    parameter int CAL_AW = 9,
    parameter int CHAN_W = 8,
    parameter int SW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_we_n,
    input logic [CAL_AW-1:0] cal_addr,
    input logic [CHAN_W-1:0] cal_wdata,
    input logic [CHAN_W-1:0] cal_rdata,
    input logic [SW-1:0]     stat_out,
    input logic              frame_mark
);
    assert_sync_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |-> stat_out == SW'(2'b11))
        else $error("framing slot without framing code");

    assert_frame_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |=> !frame_mark)
        else $error("framing slot repeated");

    assert_cal_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_we_n) ##1 (cal_we_n && cal_addr == $past(cal_addr))
            |-> cal_rdata == $past(cal_wdata))
        else $error("calendar readback differs from write");

    assert_mark_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_out != SW'(2'b11)) |-> !frame_mark)
        else $error("frame mark on a non-framing code");

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R10: assert (stat_out == '0 && !frame_mark)
                else $error("outputs active during reset");
        end
    end
endmodule

bind lnk_stat_tx lst_chk #(.CAL_AW(CAL_AW), .CHAN_W(CHAN_W), .SW(SW)) u_lst_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_we_n  (cal_we_n),
    .cal_addr  (cal_addr),
    .cal_wdata (cal_wdata),
    .cal_rdata (cal_rdata),
    .stat_out  (stat_out),
    .frame_mark(frame_mark)
);

// File: tb/lnk_stat_tx_bench.sv
module lnk_stat_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_we_n = 1'b1;
    logic [8:0]  cal_addr = '0;
    logic [7:0]  cal_wdata = '0;
    logic [7:0]  cal_rdata;
    logic [9:0]  cal_len = 10'd1;
    logic [3:0]  cal_reps = 4'd1;
    logic        st_wr = 1'b0;
    logic [3:0]  st_grp = '0;
    logic [31:0] st_data = '0;
    logic        dip_err_req = 1'b0;
    logic [1:0]  stat_out;
    logic        frame_mark;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0] cal_ref [512];
    logic [1:0] st_ref  [256];

    typedef struct packed {
        logic [9:0] len;
        logic [3:0] reps;
        logic [7:0] seed;
        logic       err;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{len: 10'd8,   reps: 4'd1, seed: 8'h11, err: 1'b0},
        '{len: 10'd5,   reps: 4'd3, seed: 8'h2a, err: 1'b1},
        '{len: 10'd300, reps: 4'd1, seed: 8'h5c, err: 1'b0},
        '{len: 10'd0,   reps: 4'd0, seed: 8'h73, err: 1'b1},
        '{len: 10'd600, reps: 4'd1, seed: 8'h0f, err: 1'b0}
    };

    always #2 clk = ~clk;

    lnk_stat_tx u_lnk_stat_tx (
        .clk(clk), .rst_n(rst_n), .cal_we_n(cal_we_n), .cal_addr(cal_addr),
        .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .cal_len(cal_len),
        .cal_reps(cal_reps), .st_wr(st_wr), .st_grp(st_grp), .st_data(st_data),
        .dip_err_req(dip_err_req), .stat_out(stat_out), .frame_mark(frame_mark)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cal_write(input int a, input logic [7:0] d);
        cal_we_n = 1'b0; cal_addr = 9'(a); cal_wdata = d;
        @(negedge clk);
        cal_we_n = 1'b1;
        cal_ref[a] = d;
    endtask

    task automatic stat_write(input int g, input logic [31:0] d);
        st_wr = 1'b1; st_grp = 4'(g); st_data = d;
        @(negedge clk);
        st_wr = 1'b0;
        for (int k = 0; k < 16; k++) st_ref[g*16+k] = d[2*k +: 2];
    endtask

    task automatic wait_frame();
        while (!frame_mark) @(negedge clk);
    endtask

    // Called while the framing slot is visible; ends on the next framing slot.
    task automatic capture(input int len_e, input int reps_e, input bit exp_err,
                           input bit pulse, input int chg_len);
        logic [1:0] acc, exp_s, dipx;
        chk(frame_mark === 1'b1 && stat_out == 2'b11, "R5 framing code", stat_out, 3);
        acc = 2'b00;
        for (int r = 0; r < reps_e; r++) begin
            for (int i = 0; i < len_e; i++) begin
                @(negedge clk);
                exp_s = st_ref[cal_ref[i]];
                chk(stat_out == exp_s && !frame_mark,
                    $sformatf("R6 slot rep%0d entry%0d", r, i), stat_out, exp_s);
                acc = {acc[0], acc[1]} ^ exp_s;
                if (r == 0 && i == 0) begin
                    if (pulse) dip_err_req = 1'b1;
                    if (chg_len != 0) cal_len = 10'(chg_len);
                end
            end
        end
        @(negedge clk);
        dipx = exp_err ? acc : ~acc;
        chk(stat_out == dipx, exp_err ? "R9 forced parity" : "R8 parity", stat_out, dipx);
        if (pulse) dip_err_req = 1'b0;
        @(negedge clk);
        chk(frame_mark === 1'b1, "R5 next frame follows parity", frame_mark, 1);
    endtask

    // Vector table walk, then directed tests
    initial begin
        for (int c = 0; c < 256; c++) st_ref[c] = 2'b00;
        repeat (3) @(negedge clk);
        chk(stat_out == 2'b00 && !frame_mark, "R10 reset outputs", stat_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_mark === 1'b1, "R10 first frame after release", frame_mark, 1);

        for (int v = 0; v < 5; v++) begin
            int len_e, reps_e;
            logic [7:0] sd;
            sd     = VECS[v].seed;
            len_e  = (VECS[v].len == 0) ? 1 : ((VECS[v].len > 512) ? 512 : int'(VECS[v].len));
            reps_e = (VECS[v].reps == 0) ? 1 : int'(VECS[v].reps);
            cal_len  = VECS[v].len;
            cal_reps = VECS[v].reps;
            // R3: each group word places channel 16*g+k in bits [2k+1:2k]
            for (int g = 0; g < 16; g++)
                stat_write(g, {sd ^ 8'(g), 8'(g*29) ^ 8'ha5, 8'(sd + 8'(g)), ~sd});
            // R1: calendar loaded with a seed-dependent channel order
            for (int i = 0; i < len_e; i++) cal_write(i, 8'(sd + 8'(i*13)));
            cal_addr = '0; #1;
            chk(cal_rdata == cal_ref[0], "R2 calendar read entry 0", cal_rdata, cal_ref[0]);
            cal_addr = 9'(len_e - 1); #1;
            chk(cal_rdata == cal_ref[len_e-1], "R1 calendar read last entry",
                cal_rdata, cal_ref[len_e-1]);
            @(negedge clk);
            wait_frame();
            // R7: zero and oversize settings clamp; R9 pulse on flagged vectors
            capture(len_e, reps_e, VECS[v].err, VECS[v].err, 0);
        end

        // R7: length change inside a frame applies from the next frame only
        cal_len = 10'd6; cal_reps = 4'd2;
        @(negedge clk);
        wait_frame();
        capture(len_e_of(6), 2, 1'b0, 1'b0, 3);
        capture(3, 2, 1'b0, 1'b0, 0);

        // R9: request held high across frames corrupts only the first parity
        dip_err_req = 1'b1;
        capture(3, 2, 1'b1, 1'b0, 0);
        capture(3, 2, 1'b0, 1'b0, 0);
        dip_err_req = 1'b0;
        capture(3, 2, 1'b0, 1'b0, 0);

        // R10 / R4: reset mid-run clears status; calendar contents stay
        rst_n = 1'b0; #1;
        chk(stat_out == 2'b00 && !frame_mark, "R10 outputs in reset", stat_out, 0);
        for (int c = 0; c < 256; c++) st_ref[c] = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_mark === 1'b1, "R10 frame restarts after reset", frame_mark, 1);
        capture(3, 2, 1'b0, 1'b0, 0);   // R4: unwritten status is 00, parity 11

        // R3: single-channel mapping check, channel 9*16+3
        stat_write(9, 32'h0000_0080);
        cal_write(0, 8'd147);
        cal_len = 10'd1; cal_reps = 4'd1;
        @(negedge clk);
        wait_frame();
        @(negedge clk);
        wait_frame();
        @(negedge clk);
        chk(stat_out == 2'b10, "R3 group bit position", stat_out, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic int len_e_of(input int l);
        return l;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule